// File: doc/BRIEF.md
# Sample Buffer Position Counter

This block tracks where a play device and a capture device stand inside their circular sample buffers. Each device owns a region of 4096 slots, and each slot holds one 32-bit mono sample. Each device has a 12-bit position counter. The counter steps once for every sample strobe while the device's run flag is high. A host-driven zero control forces the counter to zero and keeps it there for as long as the control is held.

The host reads a packed 20-bit position word. For each device the word carries only the upper 10 bits of the counter, so one visible step covers four samples. The block also produces the byte address of the current slot for each device. The address combines a fixed region base, a selectable channel buffer and the counter.

An interrupt is raised each time either counter reaches the middle of its buffer or wraps back to the start. The interrupt stays pending until the host raises its clear control and then drops it.

Top module: `sample_pos_counter`

## Requirements
- R1: After reset both counters are zero, the position word is 0 and the interrupt output is low.
- R2: A device's counter increases by exactly one on each clock edge where the sample strobe and that device's run flag are both high and its zero control is low; otherwise it keeps its value.
- R3: The counter is 12 bits wide: a step from 0xFFF gives 0x000.
- R4: On the clock edge after a device's zero control is sampled high, its counter is zero. It stays zero, ignoring strobes, for as long as the control remains high.
- R5: Position word bits 9..0 hold the play counter bits 11..2, and bits 19..10 hold the capture counter bits 11..2.
- R6: The interrupt output goes high on the same edge at which either counter steps from 0x7FF to 0x800 or from 0xFFF to 0x000. A counter forced to zero by its zero control raises no interrupt.
- R7: Once high, the interrupt stays high until an edge at which the clear control is sampled low after being sampled high on the previous edge. It then goes low, unless a new R6 event occurs on that same edge.
- R8: The play byte address is chan×0x4000 + counter×4. The capture byte address is 0x10000 + chan×0x4000 + counter×4. In both cases chan is that device's 2-bit channel select.
- R9: The two devices are independent: the run flag, zero control and channel select of one never change the other's counter or address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | One-cycle pulse per sample period |
| play_run | input | 1 | Play device running |
| cap_run | input | 1 | Capture device running |
| play_zero | input | 1 | Hold play counter at zero |
| cap_zero | input | 1 | Hold capture counter at zero |
| irq_clr | input | 1 | Interrupt clear control (set, then clear) |
| play_chan | input | 2 | Play channel buffer select |
| cap_chan | input | 2 | Capture channel buffer select |
| pos_word | output | 20 | Packed host-visible positions |
| play_addr | output | 17 | Play slot byte address |
| cap_addr | output | 17 | Capture slot byte address |
| irq | output | 1 | Pending interrupt |

## Verification
The assertions check the following on every cycle:
- the hold-at-zero behaviour;
- the single-step advance and its modulo wrap, observed through the address;
- the agreement between the position word and the address counter bits;
- the persistence of a pending interrupt until a clear falling edge;
- that a rising interrupt coincides with a half-point or zero counter.

The bench's scenarios are needed for the long runs that reach the half point and the wrap, and for the exact edge on which the clear handshake drops the interrupt. They also cover the case where an event coincides with the clear, and the independence of the two devices under mixed random run, zero and channel patterns.

// File: rtl/pos_pkg.sv
package pos_pkg;
    typedef enum logic {
        DEV_PLAY = 1'b0,
        DEV_CAP  = 1'b1
    } dev_e;

    localparam int unsigned NUM_DEV = 2;

    typedef struct packed {
        logic pend;
        logic clr_prev;
    } irq_state_t;
endpackage

// File: rtl/pos_counter.sv
module pos_counter #(
    parameter int unsigned CNT_W  = 12,
    parameter int unsigned CHAN_W = 2,
    parameter int unsigned ADDR_W = 17,
    parameter logic [ADDR_W-1:0] BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              run,
    input  logic              hold_zero,
    input  logic [CHAN_W-1:0] chan,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              evt_o
);
    localparam int unsigned BYTE_SHIFT  = 2;
    localparam int unsigned REGION_LOG  = CNT_W + BYTE_SHIFT;
    localparam logic [CNT_W-1:0] HALF   = CNT_W'(1) << (CNT_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       evt_d;

    always_comb begin
        st_d  = st_q;
        evt_d = 1'b0;
        if (hold_zero) begin
            st_d.cnt = '0;
        end else if (stb && run) begin
            st_d.cnt = st_q.cnt + 1'b1;
            evt_d    = (st_d.cnt == HALF) || (st_d.cnt == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign evt_o  = evt_d;
    assign addr_o = BASE
                  + (ADDR_W'(chan) << REGION_LOG)
                  + (ADDR_W'(st_q.cnt) << BYTE_SHIFT);
endmodule

// File: rtl/pos_irq_ctrl.sv
module pos_irq_ctrl
    import pos_pkg::*;
#(
    parameter int unsigned N_SRC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt,
    input  logic             clr,
    output logic             irq
);
    irq_state_t st_d, st_q;
    logic       clr_done;

    always_comb begin
        st_d          = st_q;
        clr_done      = st_q.clr_prev && !clr;
        st_d.clr_prev = clr;
        st_d.pend     = (|evt) || (st_q.pend && !clr_done);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.pend;
endmodule

// File: rtl/sample_pos_counter.sv
module sample_pos_counter
    import pos_pkg::*;
#(
    parameter int unsigned CNT_W    = 12,
    parameter int unsigned CHAN_W   = 2,
    parameter int unsigned ADDR_W   = 17,
    parameter logic [ADDR_W-1:0] PLAY_BASE = 17'h00000,
    parameter logic [ADDR_W-1:0] CAP_BASE  = 17'h10000,
    localparam int unsigned VIS_W   = CNT_W - 2,
    localparam int unsigned POS_W   = NUM_DEV * VIS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_stb,
    input  logic              play_run,
    input  logic              cap_run,
    input  logic              play_zero,
    input  logic              cap_zero,
    input  logic              irq_clr,
    input  logic [CHAN_W-1:0] play_chan,
    input  logic [CHAN_W-1:0] cap_chan,
    output logic [POS_W-1:0]  pos_word,
    output logic [ADDR_W-1:0] play_addr,
    output logic [ADDR_W-1:0] cap_addr,
    output logic              irq
);
    logic [NUM_DEV-1:0]              run_v, zero_v, evt_v;
    logic [NUM_DEV-1:0][CHAN_W-1:0]  chan_v;
    logic [NUM_DEV-1:0][CNT_W-1:0]   cnt_v;
    logic [NUM_DEV-1:0][ADDR_W-1:0]  addr_v;

    assign run_v[DEV_PLAY]  = play_run;
    assign run_v[DEV_CAP]   = cap_run;
    assign zero_v[DEV_PLAY] = play_zero;
    assign zero_v[DEV_CAP]  = cap_zero;
    assign chan_v[DEV_PLAY] = play_chan;
    assign chan_v[DEV_CAP]  = cap_chan;

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        localparam logic [ADDR_W-1:0] DEV_BASE = (d == 0) ? PLAY_BASE : CAP_BASE;

        pos_counter #(
            .CNT_W  (CNT_W),
            .CHAN_W (CHAN_W),
            .ADDR_W (ADDR_W),
            .BASE   (DEV_BASE)
        ) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .stb       (sample_stb),
            .run       (run_v[d]),
            .hold_zero (zero_v[d]),
            .chan      (chan_v[d]),
            .cnt_o     (cnt_v[d]),
            .addr_o    (addr_v[d]),
            .evt_o     (evt_v[d])
        );

        assign pos_word[d*VIS_W +: VIS_W] = cnt_v[d][CNT_W-1 -: VIS_W];
    end

    pos_irq_ctrl #(
        .N_SRC (NUM_DEV)
    ) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt_v),
        .clr   (irq_clr),
        .irq   (irq)
    );

    assign play_addr = addr_v[DEV_PLAY];
    assign cap_addr  = addr_v[DEV_CAP];
endmodule

// File: rtl/pos_checker.sv
module pos_checker #(
    parameter int unsigned CNT_W  = 12,
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned POS_W  = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_stb,
    input logic              play_run,
    input logic              play_zero,
    input logic              irq_clr,
    input logic [POS_W-1:0]  pos_word,
    input logic [ADDR_W-1:0] play_addr,
    input logic [ADDR_W-1:0] cap_addr,
    input logic              irq
);
    localparam int unsigned VIS_W = CNT_W - 2;
    localparam logic [CNT_W-1:0] HALF = CNT_W'(1) << (CNT_W - 1);

    logic [CNT_W-1:0] play_c, cap_c;
    assign play_c = play_addr[CNT_W+1:2];
    assign cap_c  = cap_addr[CNT_W+1:2];

    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        play_zero |=> (play_c == '0)); // R4

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!play_zero && !(sample_stb && play_run)) |=> $stable(pos_word[VIS_W-1:0])); // R2

    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!play_zero && sample_stb && play_run) |=> (play_c == CNT_W'($past(play_c) + 1'b1))); // R3

    AST_POS_PACK: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_word[VIS_W-1:0] == play_c[CNT_W-1:2]) && (pos_word[2*VIS_W-1:VIS_W] == cap_c[CNT_W-1:2])); // R5

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (play_c == HALF || play_c == '0 || cap_c == HALF || cap_c == '0)); // R6

    AST_IRQ_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !$fell(irq_clr)) |=> irq); // R7
endmodule

bind sample_pos_counter pos_checker #(
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .POS_W  (POS_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .play_run   (play_run),
    .play_zero  (play_zero),
    .irq_clr    (irq_clr),
    .pos_word   (pos_word),
    .play_addr  (play_addr),
    .cap_addr   (cap_addr),
    .irq        (irq)
);

// File: tb/sim_sample_pos_counter.sv
module sim_sample_pos_counter;
    localparam int CNT_W = 12;
    localparam int LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_stb = 0, play_run = 0, cap_run = 0, play_zero = 0, cap_zero = 0, irq_clr = 0;
    logic [1:0] play_chan = 0, cap_chan = 0;
    logic [19:0] pos_word;
    logic [16:0] play_addr, cap_addr;
    logic irq;

    always #2 clk = ~clk;

    sample_pos_counter u0 (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
        .play_run(play_run), .cap_run(cap_run),
        .play_zero(play_zero), .cap_zero(cap_zero), .irq_clr(irq_clr),
        .play_chan(play_chan), .cap_chan(cap_chan),
        .pos_word(pos_word), .play_addr(play_addr), .cap_addr(cap_addr), .irq(irq)
    );

    int n_run = 0, n_fail = 0;
    bit done = 0;
    bit [11:0] m_play = 0, m_cap = 0;
    bit m_pend = 0, m_clr_prev = 0;

    function automatic bit [16:0] exp_addr(bit cap, bit [1:0] ch, bit [11:0] c);
        return (cap ? 17'h10000 : 17'h0) + {ch, 14'h0} + {3'b0, c, 2'b00};
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R5 play pos", int'(pos_word[9:0]), int'(m_play[11:2]));
        chk("R5 cap pos", int'(pos_word[19:10]), int'(m_cap[11:2]));
        chk("R8 play addr", int'(play_addr), int'(exp_addr(0, play_chan, m_play)));
        chk("R8 cap addr", int'(cap_addr), int'(exp_addr(1, cap_chan, m_cap)));
        chk("R6/R7 irq", int'(irq), int'(m_pend));
    endtask

    task automatic model_edge();
        bit ev = 0;
        if (play_zero) m_play = 0;
        else if (sample_stb && play_run) begin
            m_play = m_play + 1'b1;
            if (m_play == 12'h800 || m_play == 12'h000) ev = 1;
        end
        if (cap_zero) m_cap = 0;
        else if (sample_stb && cap_run) begin
            m_cap = m_cap + 1'b1;
            if (m_cap == 12'h800 || m_cap == 12'h000) ev = 1;
        end
        m_pend = ev || (m_pend && !(m_clr_prev && !irq_clr));
        m_clr_prev = irq_clr;
    endtask

    task automatic step(bit s, bit pr, bit cr, bit pz, bit cz, bit c, bit [1:0] pch, bit [1:0] cch);
        @(negedge clk);
        sample_stb = s; play_run = pr; cap_run = cr; play_zero = pz; cap_zero = cz;
        irq_clr = c; play_chan = pch; cap_chan = cch;
        @(posedge clk);
        model_edge();
        #1;
        check_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(LIMIT * 4);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 pos", int'(pos_word), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 play addr", int'(play_addr), 0);
        @(negedge clk); rst_n = 1;

        // play only: capture stays put (R9)
        for (int i = 0; i < 10; i++) step(1, 1, 0, 0, 0, 0, 2'd1, 2'd2);
        chk("R9 cap untouched", int'(pos_word[19:10]), 0);
        chk("R2 play count 10", int'(play_addr[13:2]), 10);
        // no strobe: hold (R2)
        for (int i = 0; i < 4; i++) step(0, 1, 1, 0, 0, 0, 2'd1, 2'd2);
        chk("R2 held", int'(play_addr[13:2]), 10);
        // reach half point
        for (int i = 0; i < 2038; i++) step(1, 1, 0, 0, 0, 0, 2'd3, 2'd0);
        chk("R6 half irq", int'(irq), 1);
        // clear handshake (R7)
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 2'd3, 2'd0);
        chk("R7 pending while low", int'(irq), 1);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 1, 2'd3, 2'd0);
        chk("R7 pending while high", int'(irq), 1);
        step(0, 0, 0, 0, 0, 0, 2'd3, 2'd0);
        chk("R7 cleared", int'(irq), 0);
        // wrap (R3)
        for (int i = 0; i < 2048; i++) step(1, 1, 0, 0, 0, 0, 2'd0, 2'd0);
        chk("R3 wrapped", int'(play_addr[13:2]), 0);
        chk("R6 wrap irq", int'(irq), 1);
        step(0, 0, 0, 0, 0, 1, 2'd0, 2'd0);
        // event on clearing edge keeps irq (R7)
        for (int i = 0; i < 2047; i++) step(1, 0, 1, 0, 0, 1, 2'd0, 2'd1);
        step(1, 0, 1, 0, 0, 0, 2'd0, 2'd1);
        chk("R7 event beats clear", int'(irq), 1);
        step(0, 0, 0, 0, 0, 1, 2'd0, 2'd1);
        step(0, 0, 0, 0, 0, 0, 2'd0, 2'd1);
        // zero hold with strobes (R4)
        for (int i = 0; i < 20; i++) step(1, 1, 1, 0, 0, 0, 2'd2, 2'd3);
        for (int i = 0; i < 5; i++) step(1, 1, 1, 1, 0, 0, 2'd2, 2'd3);
        chk("R4 play held zero", int'(pos_word[9:0]), 0);
        chk("R4 play addr zero", int'(play_addr), int'(exp_addr(0, 2'd2, 12'd0)));
        chk("R9 cap kept running", int'(cap_addr[13:2]), int'(m_cap));
        // random mix
        for (int i = 0; i < 12000; i++) begin
            step(1'($urandom), 1'($urandom_range(3) != 0), 1'($urandom_range(3) != 0),
                 1'($urandom_range(63) == 0), 1'($urandom_range(63) == 0),
                 1'($urandom_range(7) == 0), 2'($urandom), 2'($urandom));
        end
        finish_run();
    end
endmodule